// File: doc/BRIEF.md
# Nonvolatile store/recall sequencer

This controller sits beside a shadowed SRAM and decides when the whole array is copied into its nonvolatile shadow (a store) and when the shadow is copied back (a recall). It watches two supply comparators, one at the switch threshold and one at the lower reset level. It also watches a sampled active-low hardware store request, a single-cycle software store request and a pulse from the bus interface for each SRAM write. It drives an open-drain-style busy line, an SRAM access inhibit, a write-only inhibit, and single-cycle start strobes for the store and recall engines. The durations of those engines are fixed cycle counts given as parameters.

A store runs only when it is worth running. Hardware and automatic requests are dropped when no SRAM write has been accepted since the last store or recall. A software request always stores. A hardware request first opens a grace window, in which reads go on and a write already in flight still counts. After the store, the block stays locked until the request line returns high. A fall below the reset level abandons any activity and arms a recall. The recall runs as soon as the supply is back above the switch threshold.

Top module: `nv_seq`

## Requirements
- R1: During and after reset busy_no is 1, acc_inhibit_o is 1 and no strobe is high. Reset arms a recall: with both supply flags at 1, recall_start_o pulses for one cycle. acc_inhibit_o, wr_inhibit_o and busy_no stay high for exactly RECALL_CYC cycles counted from that strobe cycle, and acc_inhibit_o falls in the next cycle.
- R2: When hw_req_ni is low and no write has been accepted since the last store or recall, no store strobe occurs and busy_no stays 1. After the grace window the block enters the locked condition (acc_inhibit_o = 1).
- R3: After hw_req_ni is sampled low, the grace window lasts GRACE_CYC cycles: acc_inhibit_o = 0 and wr_inhibit_o = 1. A write pulse accepted inside the window makes the store happen. store_start_o is high in the cycle that follows the window.
- R4: During every store busy_no is 0 for exactly STORE_CYC consecutive cycles, beginning in the store_start_o cycle, and acc_inhibit_o is 1 throughout. busy_no = 0 means the line is driven low.
- R5: After a store while hw_req_ni is still low, acc_inhibit_o stays 1 until hw_req_ni is 1. It is 0 one cycle after hw_req_ni rises.
- R6: A software request (sw_req_i = 1 for one cycle) starts a store even when no write has been accepted. Afterwards the block returns to normal access (acc_inhibit_o = 0) when hw_req_ni is 1.
- R7: A write pulse presented while acc_inhibit_o is 1 is not counted. A later hardware request is then skipped as in R2.
- R8: In any cycle with vsw_ok_i = 0, wr_inhibit_o is 1. A fall of vsw_ok_i with a write pending starts a store. A fall without a pending write drives busy_no to 0 for exactly PULSE_CYC cycles with no store strobe. Either way acc_inhibit_o then stays 1 until vsw_ok_i is 1 again, and no recall follows unless vrst_ok_i fell.
- R9: Hardware, automatic and software triggers arriving in the same cycle produce exactly one store. Store and recall strobes are never high together and each lasts one cycle.
- R10: vrst_ok_i = 0 abandons any activity without a store and holds acc_inhibit_o = 1. When the supply is back above the switch threshold a recall runs (R1 timing) and clears the pending-write flag.
- R11: A software request arriving during a recall is held and runs as a store after the recall completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vsw_ok_i | input | 1 | Supply above the switch threshold |
| vrst_ok_i | input | 1 | Supply above the reset level |
| hw_req_ni | input | 1 | Sampled hardware store request, active low |
| sw_req_i | input | 1 | Software store request, one-cycle pulse |
| wr_pulse_i | input | 1 | One pulse per SRAM write from the bus interface |
| busy_no | output | 1 | Busy line drive; 0 pulls the line low, 1 releases it |
| acc_inhibit_o | output | 1 | Blocks all SRAM reads and writes |
| wr_inhibit_o | output | 1 | Blocks SRAM writes |
| store_start_o | output | 1 | One-cycle start strobe to the store engine |
| recall_start_o | output | 1 | One-cycle start strobe to the recall engine |

## Verification
Hardware requests are tried in three variants: with no write, with a write before the request, and with a write inside the grace window. Together they separate a skipped store from a real one and show that in-flight writes are honoured. Software requests are tried with no write and during a recall, which shows that the write rule does not apply to them and that a held request is replayed. Supply drops below the switch threshold, with and without a pending write, separate a full store from the short busy pulse. Drops below the reset level, and a cycle with all three triggers at once, show that a recall clears the write flag and that coinciding triggers give exactly one store.

// File: rtl/nv_seq_pkg.sv
package nv_seq_pkg;
  typedef enum logic [2:0] {
    ST_WAIT_UP,
    ST_RECALL,
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_PULSE,
    ST_LOCK,
    ST_DOWN
  } nv_state_e;
endpackage

// File: rtl/nv_seq_timer.sv
module nv_seq_timer #(
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [TW-1:0] len_i,
  output logic          done_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // high in the last cycle of a loaded window
  assign done_o = (cnt_q == TW'(1));
endmodule

// File: rtl/nv_seq_track.sv
module nv_seq_track (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_pulse_i,
  input  logic acc_inh_i,
  input  logic sw_req_i,
  input  logic clr_dirty_i,
  input  logic clr_sw_i,
  output logic dirty_o,
  output logic sw_pend_o
);
  logic dirty_q, sw_q, wr_ok;

  assign wr_ok = wr_pulse_i & ~acc_inh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dirty_q <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      if (clr_dirty_i)   dirty_q <= 1'b0;
      else if (wr_ok)    dirty_q <= 1'b1;
      if (clr_sw_i)      sw_q <= 1'b0;
      else if (sw_req_i) sw_q <= 1'b1;
    end
  end

  // lookahead so a write in the last grace cycle still counts
  assign dirty_o   = dirty_q | wr_ok;
  assign sw_pend_o = sw_q | sw_req_i;
endmodule

// File: rtl/nv_seq_fsm.sv
module nv_seq_fsm
  import nv_seq_pkg::*;
#(
  parameter int GRACE_CYC  = 6,
  parameter int STORE_CYC  = 30,
  parameter int RECALL_CYC = 12,
  parameter int PULSE_CYC  = 3,
  parameter int TW         = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vsw_ok_i,
  input  logic          vrst_ok_i,
  input  logic          hw_req_ni,
  input  logic          dirty_i,
  input  logic          sw_pend_i,
  input  logic          t_done_i,
  output logic          t_load_o,
  output logic [TW-1:0] t_len_o,
  output logic          busy_no,
  output logic          acc_inh_o,
  output logic          wr_inh_o,
  output logic          store_start_o,
  output logic          recall_start_o
);
  nv_state_e state_q, state_d, auto_go;
  logic      entry_q;

  assign auto_go = dirty_i ? ST_STORE : ST_PULSE;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_WAIT_UP: if (vsw_ok_i) state_d = ST_RECALL;
      ST_RECALL:  if (t_done_i) state_d = ST_IDLE;
      ST_IDLE: begin
        if (!vsw_ok_i)       state_d = auto_go;
        else if (!hw_req_ni) state_d = ST_GRACE;
        else if (sw_pend_i)  state_d = ST_STORE;
      end
      ST_GRACE: begin
        if (!vsw_ok_i)     state_d = auto_go;
        else if (t_done_i) state_d = dirty_i ? ST_STORE : ST_LOCK;
      end
      ST_STORE: begin
        if (t_done_i) begin
          if (!vsw_ok_i)       state_d = ST_DOWN;
          else if (!hw_req_ni) state_d = ST_LOCK;
          else                 state_d = ST_IDLE;
        end
      end
      ST_PULSE: if (t_done_i) state_d = ST_DOWN;
      ST_LOCK: begin
        if (!vsw_ok_i)      state_d = auto_go;
        else if (hw_req_ni) state_d = ST_IDLE;
      end
      ST_DOWN: if (vsw_ok_i) state_d = ST_IDLE;
      default: state_d = ST_WAIT_UP;
    endcase
    if (!vrst_ok_i) state_d = ST_WAIT_UP;
  end

  always_comb begin
    t_load_o = 1'b0;
    t_len_o  = '0;
    if (state_d != state_q) begin
      unique case (state_d)
        ST_RECALL: begin t_load_o = 1'b1; t_len_o = TW'(RECALL_CYC); end
        ST_GRACE:  begin t_load_o = 1'b1; t_len_o = TW'(GRACE_CYC);  end
        ST_STORE:  begin t_load_o = 1'b1; t_len_o = TW'(STORE_CYC);  end
        ST_PULSE:  begin t_load_o = 1'b1; t_len_o = TW'(PULSE_CYC);  end
        default:   t_load_o = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_UP;
      entry_q <= 1'b0;
    end else begin
      state_q <= state_d;
      entry_q <= (state_d != state_q);
    end
  end

  // outputs depend on state only, plus supply/request for the idle write gate
  always_comb begin
    busy_no   = 1'b1;
    acc_inh_o = 1'b1;
    wr_inh_o  = 1'b1;
    unique case (state_q)
      ST_IDLE: begin
        acc_inh_o = 1'b0;
        wr_inh_o  = ~vsw_ok_i | ~hw_req_ni;
      end
      ST_GRACE: acc_inh_o = 1'b0;
      ST_STORE, ST_PULSE: busy_no = 1'b0;
      default: busy_no = 1'b1;
    endcase
  end

  assign store_start_o  = entry_q && (state_q == ST_STORE);
  assign recall_start_o = entry_q && (state_q == ST_RECALL);
endmodule

// File: rtl/nv_seq.sv
module nv_seq #(
  parameter int GRACE_CYC  = 6,
  parameter int STORE_CYC  = 30,
  parameter int RECALL_CYC = 12,
  parameter int PULSE_CYC  = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic vsw_ok_i,
  input  logic vrst_ok_i,
  input  logic hw_req_ni,
  input  logic sw_req_i,
  input  logic wr_pulse_i,
  output logic busy_no,
  output logic acc_inhibit_o,
  output logic wr_inhibit_o,
  output logic store_start_o,
  output logic recall_start_o
);
  localparam int MAX_A = (GRACE_CYC > PULSE_CYC) ? GRACE_CYC : PULSE_CYC;
  localparam int MAX_B = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int MAX_L = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int TW    = $clog2(MAX_L + 1);

  logic          dirty, sw_pend, t_done, t_load;
  logic [TW-1:0] t_len;
  logic          clr_dirty, clr_sw;

  assign clr_dirty = store_start_o | recall_start_o;
  assign clr_sw    = store_start_o | ~vsw_ok_i | ~vrst_ok_i;

  nv_seq_track u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_pulse_i (wr_pulse_i),
    .acc_inh_i  (acc_inhibit_o),
    .sw_req_i   (sw_req_i),
    .clr_dirty_i(clr_dirty),
    .clr_sw_i   (clr_sw),
    .dirty_o    (dirty),
    .sw_pend_o  (sw_pend)
  );

  nv_seq_timer #(.TW(TW)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(t_load),
    .len_i (t_len),
    .done_o(t_done)
  );

  nv_seq_fsm #(
    .GRACE_CYC (GRACE_CYC),
    .STORE_CYC (STORE_CYC),
    .RECALL_CYC(RECALL_CYC),
    .PULSE_CYC (PULSE_CYC),
    .TW        (TW)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .vsw_ok_i      (vsw_ok_i),
    .vrst_ok_i     (vrst_ok_i),
    .hw_req_ni     (hw_req_ni),
    .dirty_i       (dirty),
    .sw_pend_i     (sw_pend),
    .t_done_i      (t_done),
    .t_load_o      (t_load),
    .t_len_o       (t_len),
    .busy_no       (busy_no),
    .acc_inh_o     (acc_inhibit_o),
    .wr_inh_o      (wr_inhibit_o),
    .store_start_o (store_start_o),
    .recall_start_o(recall_start_o)
  );
endmodule

// File: rtl/nv_seq_chk.sv
module nv_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic vsw_ok_i,
  input logic busy_no,
  input logic acc_inhibit_o,
  input logic wr_inhibit_o,
  input logic store_start_o,
  input logic recall_start_o
);
  // R4
  store_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |-> (!busy_no && acc_inhibit_o));
  // R4
  busy_inh_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_no |-> acc_inhibit_o);
  // R1
  recall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    recall_start_o |-> (busy_no && acc_inhibit_o && wr_inhibit_o));
  // R8
  low_supply_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsw_ok_i |-> wr_inhibit_o);
  // R7
  inh_covers_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_inhibit_o |-> wr_inhibit_o);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(store_start_o && recall_start_o));
  // R9
  store_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_start_o |=> !store_start_o);
endmodule

bind nv_seq nv_seq_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .vsw_ok_i      (vsw_ok_i),
  .busy_no       (busy_no),
  .acc_inhibit_o (acc_inhibit_o),
  .wr_inhibit_o  (wr_inhibit_o),
  .store_start_o (store_start_o),
  .recall_start_o(recall_start_o)
);

// File: tb/nv_seq_bench.sv
`timescale 1ns/1ps
module nv_seq_bench;
  localparam int GRACE  = 6;
  localparam int STORE  = 30;
  localparam int RECALL = 12;
  localparam int PULSE  = 3;
  localparam int K_STORE = 0, K_BUSY = 1, K_RECALL = 2;

  typedef struct {
    int    kind;
    int    width;
    string req;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vsw = 1'b1, vrst = 1'b1, hw_n = 1'b1, sw = 1'b0, wr = 1'b0;
  logic busy_n, acc_inh, wr_inh, st_go, rc_go;

  int   n_chk = 0, n_bad = 0;
  bit   fin = 1'b0;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  nv_seq #(.GRACE_CYC(GRACE), .STORE_CYC(STORE), .RECALL_CYC(RECALL),
           .PULSE_CYC(PULSE)) u_nv_seq (
    .clk_i(clk), .rst_ni(rst_n), .vsw_ok_i(vsw), .vrst_ok_i(vrst),
    .hw_req_ni(hw_n), .sw_req_i(sw), .wr_pulse_i(wr),
    .busy_no(busy_n), .acc_inhibit_o(acc_inh), .wr_inhibit_o(wr_inh),
    .store_start_o(st_go), .recall_start_o(rc_go)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic expect_ev(int kind, int width, string req);
    exp_t e;
    e.kind = kind; e.width = width; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic expect_store(string req);
    expect_ev(K_STORE, 0, req);
    expect_ev(K_BUSY, STORE, "R4");
  endtask

  task automatic wr_once();
    wr = 1'b1; tick(1); wr = 1'b0;
  endtask

  task automatic got(int kind, int width);
    exp_t e;
    n_chk++;
    if (exp_q.size() == 0) begin
      n_bad++;
      $display("FAIL R9 unexpected event: actual kind %0d width %0d expected none",
               kind, width);
    end else begin
      e = exp_q.pop_front();
      if (e.kind != kind || e.width != width) begin
        n_bad++;
        $display("FAIL %s event: actual kind %0d width %0d expected kind %0d width %0d",
                 e.req, kind, width, e.kind, e.width);
      end
    end
  endtask

  // monitor: store strobes, busy-low widths, recall-inhibit widths
  int  bcnt = 0, rcnt = 0;
  bit  r_on = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (st_go) got(K_STORE, 0);
      if (!busy_n) bcnt++;
      else if (bcnt > 0) begin got(K_BUSY, bcnt); bcnt = 0; end
      if (rc_go) begin r_on = 1'b1; rcnt = 1; end
      else if (r_on) begin
        if (acc_inh) rcnt++;
        else begin got(K_RECALL, rcnt); r_on = 1'b0; end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!fin) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    // R1 reset state
    chk(busy_n == 1'b1, "R1", "busy in reset", busy_n, 1);
    chk(acc_inh == 1'b1, "R1", "inhibit in reset", acc_inh, 1);
    chk({st_go, rc_go} == 2'b00, "R1", "strobes in reset", {st_go, rc_go}, 0);
    expect_ev(K_RECALL, RECALL, "R1");
    rst_n = 1'b1;
    tick(3);
    chk(acc_inh && wr_inh && busy_n, "R1", "recall gating",
        {acc_inh, wr_inh, busy_n}, 7);
    tick(12);
    chk(acc_inh == 1'b0, "R1", "access after recall", acc_inh, 0);

    // R2 hardware request with no write: skipped, then locked
    hw_n = 1'b0;
    tick(1);
    chk(!acc_inh && wr_inh, "R3", "grace gating", {acc_inh, wr_inh}, 1);
    tick(GRACE);
    chk(acc_inh && busy_n, "R2", "skip to lock", {acc_inh, busy_n}, 3);
    tick(3);
    chk(acc_inh == 1'b1, "R5", "lock held", acc_inh, 1);
    hw_n = 1'b1;
    tick(1);
    chk(acc_inh == 1'b0, "R5", "lock release", acc_inh, 0);

    // R3/R4/R5 write, then hardware request: real store
    tick(2);
    wr_once();
    expect_store("R3");
    hw_n = 1'b0;
    tick(GRACE);
    chk(!st_go && busy_n, "R3", "still in grace", {st_go, busy_n}, 1);
    tick(1);
    chk(st_go && !busy_n, "R3", "store after grace", {st_go, busy_n}, 2);
    tick(STORE);
    chk(acc_inh && busy_n, "R5", "locked after store", {acc_inh, busy_n}, 3);
    tick(4);
    hw_n = 1'b1;
    tick(1);
    chk(acc_inh == 1'b0, "R5", "resume after release", acc_inh, 0);

    // R3 write inside grace counts
    tick(2);
    expect_store("R3");
    hw_n = 1'b0;
    tick(2);
    wr_once();
    tick(STORE + GRACE + 4);
    hw_n = 1'b1;
    tick(2);

    // R6 software store with no write; R7 write during store ignored
    expect_store("R6");
    sw = 1'b1; tick(1); sw = 1'b0;
    tick(5);
    wr_once();
    tick(STORE);
    chk(acc_inh == 1'b0, "R6", "idle after sw store", acc_inh, 0);
    hw_n = 1'b0;
    tick(GRACE + 4);
    chk(acc_inh == 1'b1, "R7", "skip after ignored write", acc_inh, 1);
    hw_n = 1'b1;
    tick(2);

    // R8 supply drop with no write: short busy pulse only
    expect_ev(K_BUSY, PULSE, "R8");
    vsw = 1'b0;
    #1;
    chk(wr_inh == 1'b1, "R8", "write gate on low supply", wr_inh, 1);
    tick(10);
    chk(acc_inh == 1'b1, "R8", "held while low", acc_inh, 1);
    vsw = 1'b1;
    tick(2);
    chk(acc_inh == 1'b0, "R8", "resume without recall", acc_inh, 0);

    // R9 all triggers at once with a pending write: one store
    wr_once();
    expect_store("R9");
    vsw = 1'b0; hw_n = 1'b0; sw = 1'b1;
    tick(1);
    sw = 1'b0;
    tick(STORE + 9);
    chk(acc_inh == 1'b1, "R8", "down after auto store", acc_inh, 1);
    vsw = 1'b1;
    tick(GRACE + 6);
    chk(acc_inh == 1'b1, "R9", "no second store, locked", acc_inh, 1);
    hw_n = 1'b1;
    tick(2);
    chk(acc_inh == 1'b0, "R9", "idle after coinciding triggers", acc_inh, 0);

    // R10 brownout with a pending write: no store, recall clears the flag
    wr_once();
    vsw = 1'b0; vrst = 1'b0;
    tick(5);
    chk(acc_inh && busy_n, "R10", "brownout hold", {acc_inh, busy_n}, 3);
    expect_ev(K_RECALL, RECALL, "R10");
    vsw = 1'b1; vrst = 1'b1;
    tick(RECALL + 6);
    chk(acc_inh == 1'b0, "R10", "idle after recall", acc_inh, 0);
    hw_n = 1'b0;
    tick(GRACE + 4);
    chk(acc_inh == 1'b1, "R10", "skip after recall", acc_inh, 1);
    hw_n = 1'b1;
    tick(2);

    // R11 software request during recall is replayed afterwards
    vsw = 1'b0; vrst = 1'b0;
    tick(3);
    expect_ev(K_RECALL, RECALL, "R11");
    expect_store("R11");
    vsw = 1'b1; vrst = 1'b1;
    tick(3);
    sw = 1'b1; tick(1); sw = 1'b0;
    tick(RECALL + STORE + 10);
    chk(acc_inh == 1'b0, "R11", "idle at end", acc_inh, 0);

    chk(exp_q.size() == 0, "R9", "events outstanding", exp_q.size(), 0);
    fin = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule